// File: doc/BRIEF.md
# Synchronized Quadrature Position Counter

This block turns the two phase outputs of an incremental rotary or optical encoder into a 24-bit position value within one clock domain. The phase lines arrive asynchronously. Each one is sampled through its own two-stage synchronizer. The decoder then compares the newest synchronized phase pair with the pair seen one clock earlier. That comparison produces one step forward, one step backward, no movement, or an illegal jump in which both phases changed together.

Each legal step moves the position register up or down by one, and the value wraps at 2^24 in both directions. A host can preset the register to any value, and a preset wins over a step that lands in the same cycle. An illegal jump leaves the position alone and raises a flag for one cycle. The phases follow a gray sequence, so contact bounce on one phase only moves the count back and forth by a single step, and no debounce filter is needed.

Top module: `quad_position`

## Requirements
- R1: A change on the phase inputs, driven between clock edges, shows on `position` at the third rising edge after the change and not at the first or second.
- R2: With the phase pair written {B,A}, the forward sequence is 00, 01, 11, 10, 00. A move to the next pair in this sequence adds one to `position`. Equivalently, the ordinal {A, A xor B} falls by one modulo 4.
- R3: A move to the previous pair in that sequence subtracts one from `position`.
- R4: A phase pair that stays the same leaves `position` unchanged.
- R5: When both phases change between two consecutive samples, `position` is left unchanged and `double_step` is high for exactly one cycle for each such jump.
- R6: Counting wraps modulo 2^24. A forward step from 0xFFFFFF gives 0, and a backward step from 0 gives 0xFFFFFF.
- R7: While `preset_en` is high at a rising edge, `position` takes `preset_val` at that edge, even when a step is decoded at the same edge.
- R8: While `rst_n` is low, `position` is 0 and `double_step` is 0. After release, no step and no flag is produced until the history holds samples taken after reset, whatever the phase levels are.
- R9: One phase bouncing back and forth leaves `position` at most one step away from where it started. After an even number of toggles it is back at the start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the whole block |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| preset_en | input | 1 | Loads `preset_val` into the position register at the next edge |
| preset_val | input | 24 | Value to load |
| position | output | 24 | Current position count, driven straight from its register |
| double_step | output | 1 | One-cycle flag for a transition where both phases changed |

## Verification
The hardest case to reach from the ports is a preset and a decoded step landing on the same clock edge. The step only reaches the counter three edges after the phase change, so the bench changes a phase and then raises `preset_en` exactly two edges later. A second hard case is the start-up window right after reset. Here the inputs are held at 11 while reset is released, which would look like a double jump if the history were decoded too early. Random runs mix legal steps, holds and double jumps, each held for one to three cycles, so back-to-back jumps and single-cycle patterns also occur.

// File: rtl/qpos_pkg.sv
package qpos_pkg;

  // Outcome of comparing the newest synchronized phase pair with the previous one.
  typedef enum logic [1:0] {
    MV_HOLD = 2'd0,
    MV_FWD  = 2'd1,
    MV_REV  = 2'd2,
    MV_JUMP = 2'd3
  } move_e;

  // code = {new_b, new_a, old_b, old_a}
  function automatic move_e classify(input logic [3:0] code);
    move_e m;
    unique case (code)
      4'b0100, 4'b1101, 4'b1011, 4'b0010: m = MV_FWD;
      4'b1000, 4'b1110, 4'b0111, 4'b0001: m = MV_REV;
      4'b1100, 4'b0011, 4'b1001, 4'b0110: m = MV_JUMP;
      default:                            m = MV_HOLD;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/qpos_sync.sv
module qpos_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (g == 0) begin : g_first
      assign stage_d = async_in;
    end else begin : g_rest
      assign stage_d = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_d;
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/qpos_decode.sv
module qpos_decode
  import qpos_pkg::*;
#(
  parameter int FILL_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pair_now,   // {B,A}, synchronized
  output move_e      move,
  output logic       move_valid
);

  localparam int FW = $clog2(FILL_CYCLES + 1);
  localparam logic [FW-1:0] FILL_MAX = FW'(FILL_CYCLES);

  logic [1:0]    pair_prev_q, pair_prev_d;
  logic [FW-1:0] fill_q, fill_d;
  logic          fill_en;

  // next state
  always_comb begin
    pair_prev_d = pair_now;
    fill_en     = (fill_q != FILL_MAX);
    fill_d      = fill_en ? fill_q + FW'(1) : fill_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_prev_q <= '0;
      fill_q      <= '0;
    end else begin
      pair_prev_q <= pair_prev_d;
      if (fill_en) fill_q <= fill_d;
    end
  end

  assign move_valid = (fill_q == FILL_MAX);
  assign move       = move_valid ? classify({pair_now, pair_prev_q}) : MV_HOLD;

endmodule

// File: rtl/qpos_counter.sv
module qpos_counter
  import qpos_pkg::*;
#(
  parameter int POS_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  move_e            move,
  input  logic             load_en,
  input  logic [POS_W-1:0] load_val,
  output logic [POS_W-1:0] pos,
  output logic             jump_flag
);

  localparam logic [POS_W-1:0] ONE = POS_W'(1);

  logic [POS_W-1:0] pos_q, pos_d;
  logic             jump_q, jump_d;
  logic             pos_en;

  // next state
  always_comb begin
    pos_d  = pos_q;
    pos_en = 1'b0;
    jump_d = (move == MV_JUMP);
    if (load_en) begin
      pos_d  = load_val;
      pos_en = 1'b1;
    end else begin
      unique case (move)
        MV_FWD: begin pos_d = pos_q + ONE; pos_en = 1'b1; end
        MV_REV: begin pos_d = pos_q - ONE; pos_en = 1'b1; end
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      jump_q <= 1'b0;
    end else begin
      if (pos_en) pos_q <= pos_d;
      jump_q <= jump_d;
    end
  end

  assign pos       = pos_q;
  assign jump_flag = jump_q;

endmodule

// File: rtl/quad_position.sv
module quad_position
  import qpos_pkg::*;
#(
  parameter int POS_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             preset_en,
  input  logic [POS_W-1:0] preset_val,
  output logic [POS_W-1:0] position,
  output logic             double_step
);

  localparam int FILL_CYCLES = SYNC_STAGES + 1;

  logic [1:0] pair_sync;
  move_e      move;
  logic       move_valid;

  qpos_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({enc_b, enc_a}),
    .sync_out (pair_sync)
  );

  qpos_decode #(.FILL_CYCLES(FILL_CYCLES)) u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .pair_now   (pair_sync),
    .move       (move),
    .move_valid (move_valid)
  );

  qpos_counter #(.POS_W(POS_W)) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .move      (move),
    .load_en   (preset_en),
    .load_val  (preset_val),
    .pos       (position),
    .jump_flag (double_step)
  );

endmodule

// File: rtl/quad_position_chk.sv
module quad_position_chk #(
  parameter int POS_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             preset_en,
  input logic [POS_W-1:0] preset_val,
  input logic [POS_W-1:0] position,
  input logic             double_step
);

  logic [2:0] since_rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  since_rst_q <= '0;
    else if (since_rst_q != 3'd7) since_rst_q <= since_rst_q + 3'd1;
  end

  // R8: nothing is decoded before the history holds post-reset samples
  a_r8_quiet_warmup: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst_q < 3'd4) |-> (!double_step && (position == '0 || $past(preset_en))));

  // R7: a preset lands at the next edge and overrides any step
  a_r7_preset_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst_q != 3'd0 && $past(preset_en)) |-> position == $past(preset_val));

  // R2, R3, R6: without a preset, position moves by at most one, with wraparound
  a_r2_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst_q != 3'd0 && !$past(preset_en)) |->
      (position == $past(position) ||
       position == $past(position) + POS_W'(1) ||
       position == $past(position) - POS_W'(1)));

  // R5: a double jump never moves the position
  a_r5_jump_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst_q != 3'd0 && double_step && !$past(preset_en)) |->
      position == $past(position));

endmodule

bind quad_position quad_position_chk #(.POS_W(POS_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .preset_en   (preset_en),
  .preset_val  (preset_val),
  .position    (position),
  .double_step (double_step)
);

// File: tb/quad_position_bench.sv
module quad_position_bench;

  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         enc_a, enc_b;
  logic         preset_en;
  logic [W-1:0] preset_val;
  logic [W-1:0] position;
  logic         double_step;

  int total = 0;
  int bad   = 0;
  int flags_seen = 0;
  int flags_exp  = 0;
  int cycles = 0;
  bit mon_en = 1'b0;
  bit done   = 1'b0;
  logic [W-1:0] exp_pos;
  logic [1:0]   cur_pair;

  always #10 clk = ~clk;

  quad_position u_quad_position (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .preset_en(preset_en), .preset_val(preset_val),
    .position(position), .double_step(double_step)
  );

  always @(negedge clk) begin
    cycles++;
    if (mon_en && double_step) flags_seen++;
  end

  always @(posedge clk) begin
    if (!done && cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [1:0] ord(input logic [1:0] p); // p={B,A}
    return {p[0], p[0] ^ p[1]};
  endfunction

  function automatic int step_of(input logic [1:0] nw, input logic [1:0] od);
    logic [1:0] d;
    d = ord(od) - ord(nw);
    if (d == 2'd1) return 1;
    if (d == 2'd3) return -1;
    return 0;
  endfunction

  function automatic logic [1:0] fwd_of(input logic [1:0] p);
    case (p)
      2'b00: return 2'b01;
      2'b01: return 2'b11;
      2'b11: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [1:0] rev_of(input logic [1:0] p);
    case (p)
      2'b01: return 2'b00;
      2'b11: return 2'b01;
      2'b10: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic check_int(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // called at a negedge: drive a pair, update the model, hold n cycles
  task automatic apply(input logic [1:0] p, input int n);
    int s;
    s = step_of(p, cur_pair);
    if (p == ~cur_pair) flags_exp++;
    exp_pos = exp_pos + W'(s);
    cur_pair = p;
    {enc_b, enc_a} = p;
    repeat (n) @(negedge clk);
  endtask

  task automatic preset(input logic [W-1:0] v);
    preset_en = 1'b1; preset_val = v;
    @(negedge clk);
    preset_en = 1'b0;
    exp_pos = v;
  endtask

  initial begin
    logic [W-1:0] held;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; enc_a = 1'b1; enc_b = 1'b1;
    preset_en = 1'b0; preset_val = '0;
    cur_pair = 2'b11; exp_pos = '0;
    repeat (3) @(negedge clk);
    check("R8 reset position", position, '0);
    check("R8 reset flag", {23'd0, double_step}, '0);
    rst_n = 1'b1; mon_en = 1'b1;
    repeat (6) @(negedge clk);
    check("R8 no step after release", position, '0);
    check_int("R8 no flag after release", flags_seen, 0);

    // R1 latency: 11 -> 10 is forward
    cur_pair = 2'b10; {enc_b, enc_a} = 2'b10; exp_pos = exp_pos + 1;
    @(negedge clk); @(negedge clk);
    check("R1 unchanged after two edges", position, '0);
    @(negedge clk);
    check("R1 changed at third edge", position, W'(1));

    // R2 forward full cycle
    for (int i = 0; i < 4; i++) apply(fwd_of(cur_pair), 2);
    repeat (4) @(negedge clk);
    check("R2 forward cycle", position, W'(5));
    // R3 reverse
    for (int i = 0; i < 6; i++) apply(rev_of(cur_pair), 1);
    repeat (4) @(negedge clk);
    check("R3 reverse steps", position, exp_pos);
    // R4 hold
    apply(cur_pair, 8);
    check("R4 hold", position, exp_pos);

    // R5 double jump
    held = exp_pos;
    apply(~cur_pair, 1);
    apply(~cur_pair, 1);
    repeat (4) @(negedge clk);
    check("R5 position held on jump", position, held);
    check_int("R5 one flag per jump", flags_seen, flags_exp);

    // R6 wrap
    preset(24'hFFFFFF);
    apply(fwd_of(cur_pair), 4);
    check("R6 wrap up", position, '0);
    apply(rev_of(cur_pair), 4);
    check("R6 wrap down", position, 24'hFFFFFF);

    // R7 preset colliding with a step at the same edge
    cur_pair = fwd_of(cur_pair); {enc_b, enc_a} = cur_pair;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    preset_en = 1'b1; preset_val = 24'h5A5A5A;
    @(negedge clk);
    preset_en = 1'b0; exp_pos = 24'h5A5A5A;
    check("R7 preset wins over step", position, 24'h5A5A5A);
    repeat (4) @(negedge clk);
    check("R7 step not applied later", position, 24'h5A5A5A);

    // R9 bounce on phase A
    held = exp_pos;
    for (int i = 0; i < 6; i++) apply({cur_pair[1], ~cur_pair[0]}, 1);
    repeat (4) @(negedge clk);
    check("R9 even bounce returns", position, held);
    for (int i = 0; i < 5; i++) apply({cur_pair[1], ~cur_pair[0]}, 1);
    repeat (4) @(negedge clk);
    check("R9 odd bounce one step", position, exp_pos);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int kind, hold;
      kind = int'($urandom_range(0, 7));
      hold = int'($urandom_range(1, 3));
      if (kind < 3)       apply(fwd_of(cur_pair), hold);
      else if (kind < 6)  apply(rev_of(cur_pair), hold);
      else if (kind == 6) apply(cur_pair, hold);
      else                apply(~cur_pair, hold);
      if (it % 80 == 79) begin
        repeat (4) @(negedge clk);
        check("R2 R3 R5 random walk", position, exp_pos);
      end
    end
    repeat (4) @(negedge clk);
    check("R2 R3 random final", position, exp_pos);
    check_int("R5 random flags", flags_seen, flags_exp);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule